// File: doc/BRIEF.md
# Result Dispatch Stage with Auto-Advancing Write Port

This block is the final stage of a small command-processing core. Each cycle it may accept one operation. An operation carries a datapath result, a destination register number and a 3-bit dispatch mode. The mode decides four things:

- whether the register file receives the result or the next word taken from an input parameter queue;
- whether the result is loaded into the method register;
- whether a write is emitted on the outgoing write channel;
- what data that write carries.

The method register holds a target address and an increment. Every emitted write goes to the current address. The address then advances by the increment, so a run of sends lands on consecutive or strided targets without any further instruction.

The outgoing channel is valid/ready. While the channel is not ready, the operation is held and nothing in it takes effect. The parameter queue is read through a pop strobe. If the queue is empty, a zero is supplied instead and a sticky error flag is raised.

Top module: `result_dispatch`

## Requirements
- R1: Mode codes are 0 ignore-and-fetch, 1 move, 2 move-and-set-method, 3 fetch-and-send, 4 move-and-send, 5 fetch-and-set-method, 6 set-method-fetch-send, 7 set-method-send. In the cycle an operation is accepted, `rfWe` is asserted and `rfData` is the parameter word for modes 0, 3 and 5, and the result for all other modes.
- R2: An operation with destination 0 produces no `rfWe`. Its pop, method load and send still take place.
- R3: Modes 2, 5, 6 and 7 load result bits 17:0 into the method register: address in bits 11:0, increment in bits 17:12. The new value is visible on `methodAddr` in the cycle after acceptance. The method register changes only when an operation is accepted.
- R4: Modes 3, 4, 6 and 7 raise `wrValid`. The write address is the address field in effect, which is the newly loaded one for modes 6 and 7. The data is the result for modes 3 and 4, the popped parameter for mode 6, and result bits 17:12 zero-extended for mode 7.
- R5: After each accepted send, the address field becomes the old address plus the increment, modulo 4096. The increment is left unchanged.
- R6: While `wrValid` is high and `wrReady` is low, `opReady` is low and there is no register write, no pop and no method-register change.
- R7: Modes 0, 3, 5 and 6 pop exactly one word per accepted operation, and only when the queue is not empty. If the queue is empty, no pop occurs, the word used is 0, and `underflow` becomes 1 and stays 1 until reset.
- R8: After reset, `methodAddr` is 0 and `underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present |
| opReady | output | 1 | Operation accepted this cycle when valid |
| opMode | input | 3 | Dispatch mode |
| opDst | input | 3 | Destination register number |
| opResult | input | 32 | Datapath result |
| paramEmpty | input | 1 | Parameter queue empty |
| paramData | input | 32 | Head word of parameter queue |
| paramPop | output | 1 | Pop parameter queue |
| rfWe | output | 1 | Register file write enable |
| rfAddr | output | 3 | Register file write address |
| rfData | output | 32 | Register file write data |
| wrValid | output | 1 | Outgoing write valid |
| wrReady | input | 1 | Outgoing write accepted |
| wrAddr | output | 12 | Outgoing write address |
| wrData | output | 32 | Outgoing write data |
| methodAddr | output | 18 | Method register {increment, address} |
| underflow | output | 1 | Sticky empty-pop flag |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight registers, a 12-bit address and a 6-bit increment. At these sizes, a method value loaded near 0xFFF with an increment of 3 wraps past zero in a single send. The 6-bit field sent by mode 7 is also distinguishable from the address bits that precede it. Every mode is driven, including a destination-0 send, a held channel lasting two cycles, and a pop against an empty queue.

// File: rtl/result_dispatch_pkg.sv
package result_dispatch_pkg;

  typedef enum logic [2:0] {
    MODE_IGNORE_FETCH   = 3'd0,
    MODE_MOVE           = 3'd1,
    MODE_MOVE_SETM      = 3'd2,
    MODE_FETCH_SEND     = 3'd3,
    MODE_MOVE_SEND      = 3'd4,
    MODE_FETCH_SETM     = 3'd5,
    MODE_SETM_FETCHSEND = 3'd6,
    MODE_SETM_FIELDSEND = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SEND_RESULT = 2'd0,
    SEND_PARAM  = 2'd1,
    SEND_FIELD  = 2'd2
  } send_sel_e;

  typedef struct packed {
    logic      fire;
    logic      regFromParam;
    logic      loadMethod;
    logic      doSend;
    send_sel_e sendSel;
  } strobes_t;

endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import result_dispatch_pkg::*;
#(
  parameter int DST_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opMode,
  input  logic [DST_W-1:0] opDst,
  input  logic             paramEmpty,
  input  logic             wrReady,
  output logic             opReady,
  output logic             wrValid,
  output logic             rfWe,
  output logic             paramPop,
  output logic             underflow,
  output strobes_t         strobes
);

  logic needFetch;
  mode_e mode;

  assign mode = mode_e'(opMode);

  always_comb begin
    strobes.regFromParam = 1'b0;
    strobes.loadMethod   = 1'b0;
    strobes.doSend       = 1'b0;
    strobes.sendSel      = SEND_RESULT;
    needFetch            = 1'b0;
    unique case (mode)
      MODE_IGNORE_FETCH: begin
        strobes.regFromParam = 1'b1;
        needFetch = 1'b1;
      end
      MODE_MOVE: ;
      MODE_MOVE_SETM: strobes.loadMethod = 1'b1;
      MODE_FETCH_SEND: begin
        strobes.regFromParam = 1'b1;
        strobes.doSend = 1'b1;
        needFetch = 1'b1;
      end
      MODE_MOVE_SEND: strobes.doSend = 1'b1;
      MODE_FETCH_SETM: begin
        strobes.regFromParam = 1'b1;
        strobes.loadMethod = 1'b1;
        needFetch = 1'b1;
      end
      MODE_SETM_FETCHSEND: begin
        strobes.loadMethod = 1'b1;
        strobes.doSend = 1'b1;
        strobes.sendSel = SEND_PARAM;
        needFetch = 1'b1;
      end
      MODE_SETM_FIELDSEND: begin
        strobes.loadMethod = 1'b1;
        strobes.doSend = 1'b1;
        strobes.sendSel = SEND_FIELD;
      end
      default: ;
    endcase
  end

  assign opReady      = !strobes.doSend || wrReady;
  assign strobes.fire = opValid && opReady;
  assign wrValid      = opValid && strobes.doSend;
  assign rfWe         = strobes.fire && (opDst != '0);
  assign paramPop     = strobes.fire && needFetch && !paramEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) underflow <= 1'b0;
    else if (strobes.fire && needFetch && paramEmpty) underflow <= 1'b1;
  end

endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import result_dispatch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  localparam int M_W   = ADDR_W + INC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] opResult,
  input  logic              paramEmpty,
  input  logic [DATA_W-1:0] paramData,
  output logic [DATA_W-1:0] rfData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [M_W-1:0]    methodAddr
);

  logic [ADDR_W-1:0] addrQ;
  logic [INC_W-1:0]  incQ;
  logic [M_W-1:0]    base;
  logic [ADDR_W-1:0] curAddr;
  logic [INC_W-1:0]  curInc;
  logic [DATA_W-1:0] fetched;

  assign base    = strobes.loadMethod ? opResult[M_W-1:0] : {incQ, addrQ};
  assign curAddr = base[ADDR_W-1:0];
  assign curInc  = base[M_W-1:ADDR_W];
  assign fetched = paramEmpty ? '0 : paramData;
  assign rfData  = strobes.regFromParam ? fetched : opResult;
  assign wrAddr  = curAddr;

  always_comb begin
    unique case (strobes.sendSel)
      SEND_PARAM: wrData = fetched;
      SEND_FIELD: wrData = DATA_W'(opResult[M_W-1:ADDR_W]);
      default:    wrData = opResult;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      incQ  <= '0;
    end else if (strobes.fire) begin
      incQ  <= curInc;
      addrQ <= strobes.doSend ? ADDR_W'(curAddr + ADDR_W'(curInc)) : curAddr;
    end
  end

  assign methodAddr = {incQ, addrQ};

endmodule

// File: rtl/result_dispatch.sv
module result_dispatch
  import result_dispatch_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int INC_W     = 6,
  localparam int DST_W    = $clog2(REG_COUNT),
  localparam int M_W      = ADDR_W + INC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [2:0]        opMode,
  input  logic [DST_W-1:0]  opDst,
  input  logic [DATA_W-1:0] opResult,
  input  logic              paramEmpty,
  input  logic [DATA_W-1:0] paramData,
  output logic              paramPop,
  output logic              rfWe,
  output logic [DST_W-1:0]  rfAddr,
  output logic [DATA_W-1:0] rfData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [M_W-1:0]    methodAddr,
  output logic              underflow
);

  strobes_t strobes;

  assign rfAddr = opDst;

  dispatch_ctrl #(.DST_W(DST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opMode(opMode), .opDst(opDst),
    .paramEmpty(paramEmpty), .wrReady(wrReady), .opReady(opReady),
    .wrValid(wrValid), .rfWe(rfWe), .paramPop(paramPop),
    .underflow(underflow), .strobes(strobes)
  );

  dispatch_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opResult(opResult),
    .paramEmpty(paramEmpty), .paramData(paramData), .rfData(rfData),
    .wrAddr(wrAddr), .wrData(wrData), .methodAddr(methodAddr)
  );

endmodule

// File: rtl/result_dispatch_chk.sv
module result_dispatch_chk #(
  parameter int DST_W  = 3,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     opValid,
  input logic                     opReady,
  input logic                     paramEmpty,
  input logic                     paramPop,
  input logic                     rfWe,
  input logic [DST_W-1:0]         rfAddr,
  input logic                     wrValid,
  input logic                     wrReady,
  input logic [ADDR_W-1:0]        wrAddr,
  input logic [ADDR_W+INC_W-1:0]  methodAddr,
  input logic                     underflow
);

  p_we_on_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (opValid && opReady));

  p_no_zero_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (rfAddr != '0));

  p_method_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opReady) |=> $stable(methodAddr));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=>
      methodAddr[ADDR_W-1:0] ==
        ADDR_W'($past(wrAddr) + ADDR_W'(methodAddr[ADDR_W+INC_W-1:ADDR_W])));

  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |-> (!opReady && !rfWe && !paramPop));

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    paramPop |-> !paramEmpty);

  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(underflow) |-> underflow);

endmodule

bind result_dispatch result_dispatch_chk #(.DST_W(DST_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
  .paramEmpty(paramEmpty), .paramPop(paramPop), .rfWe(rfWe), .rfAddr(rfAddr),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
  .methodAddr(methodAddr), .underflow(underflow)
);

// File: tb/sim_result_dispatch.sv
`timescale 1ns/1ps
module sim_result_dispatch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [2:0]  opMode = '0;
  logic [2:0]  opDst = '0;
  logic [31:0] opResult = '0;
  logic        paramEmpty = 1'b0;
  logic [31:0] paramData = '0;
  logic        paramPop;
  logic        rfWe;
  logic [2:0]  rfAddr;
  logic [31:0] rfData;
  logic        wrValid;
  logic        wrReady = 1'b1;
  logic [11:0] wrAddr;
  logic [31:0] wrData;
  logic [17:0] methodAddr;
  logic        underflow;

  int checks = 0;
  int failures = 0;

  logic [11:0] mAddr = '0;
  logic [5:0]  mInc = '0;
  logic        mUnder = 1'b0;

  always #10 clk = ~clk;

  result_dispatch u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opMode(opMode), .opDst(opDst), .opResult(opResult),
    .paramEmpty(paramEmpty), .paramData(paramData), .paramPop(paramPop),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .methodAddr(methodAddr), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] mode, input logic [2:0] dst, input logic [31:0] res,
                       input logic [31:0] pdata, input bit pempty, input int stall);
    bit fetch, regParam, setM, send;
    logic [11:0] a;
    logic [5:0]  inc;
    logic [31:0] fv, sd;
    fetch    = (mode == 0) || (mode == 3) || (mode == 5) || (mode == 6);
    regParam = (mode == 0) || (mode == 3) || (mode == 5);
    setM     = (mode == 2) || (mode == 5) || (mode == 6) || (mode == 7);
    send     = (mode == 3) || (mode == 4) || (mode == 6) || (mode == 7);
    fv  = pempty ? 32'd0 : pdata;
    a   = setM ? res[11:0] : mAddr;
    inc = setM ? res[17:12] : mInc;
    sd  = (mode == 6) ? fv : (mode == 7) ? {26'd0, res[17:12]} : res;
    @(negedge clk);
    opValid = 1'b1; opMode = mode; opDst = dst; opResult = res;
    paramData = pdata; paramEmpty = pempty; wrReady = (stall == 0);
    for (int i = 0; i < stall; i++) begin
      #1;
      chk(opReady == 1'b0, "R6 opReady low while held", 32'(opReady), 0);
      chk(wrValid == 1'b1 && rfWe == 1'b0 && paramPop == 1'b0, "R6 held: valid, no write, no pop",
          {29'd0, wrValid, rfWe, paramPop}, 32'h4);
      @(negedge clk);
      chk(methodAddr == {mInc, mAddr}, "R6 method unchanged while held", 32'(methodAddr), 32'({mInc, mAddr}));
    end
    wrReady = 1'b1;
    #1;
    chk(rfWe == (dst != 0), (dst == 0) ? "R2 no write to register 0" : "R1 register write enable",
        32'(rfWe), 32'(dst != 0));
    if (dst != 0)
      chk(rfData == (regParam ? fv : res), "R1 register data", rfData, regParam ? fv : res);
    chk(paramPop == (fetch && !pempty), "R7 pop strobe", 32'(paramPop), 32'(fetch && !pempty));
    chk(wrValid == send, "R4 send valid", 32'(wrValid), 32'(send));
    if (send) begin
      chk(wrAddr == a, "R4 send address", 32'(wrAddr), 32'(a));
      chk(wrData == sd, "R4 send data", wrData, sd);
    end
    @(negedge clk);
    opValid = 1'b0;
    mInc = inc;
    mAddr = send ? 12'(a + 12'(inc)) : a;
    if (fetch && pempty) mUnder = 1'b1;
    #1;
    chk(methodAddr == {mInc, mAddr}, send ? "R5 address advanced" : "R3 method register",
        32'(methodAddr), 32'({mInc, mAddr}));
    chk(underflow == mUnder, "R7 underflow flag", 32'(underflow), 32'(mUnder));
  endtask

  task automatic testReset();
    #1;
    chk(methodAddr == 0, "R8 method after reset", 32'(methodAddr), 0);
    chk(underflow == 0, "R8 underflow after reset", 32'(underflow), 0);
  endtask

  task automatic testModes();
    runOp(3'd1, 3'd3, 32'h1234_5678, 32'h0, 1'b0, 0);
    runOp(3'd0, 3'd2, 32'hFFFF_0000, 32'hAAAA_0001, 1'b0, 0);
    runOp(3'd2, 3'd1, 32'h0000_2010, 32'h0, 1'b0, 0);
    runOp(3'd4, 3'd4, 32'h0000_DEAD, 32'h0, 1'b0, 0);
  endtask

  task automatic testZeroDst();
    runOp(3'd3, 3'd0, 32'h0000_0055, 32'h0000_0077, 1'b0, 0);
  endtask

  task automatic testWrapAndStall();
    runOp(3'd5, 3'd5, 32'h0000_3FFE, 32'h0000_0099, 1'b0, 0);
    runOp(3'd4, 3'd6, 32'h0000_0011, 32'h0, 1'b0, 2);
  endtask

  task automatic testLoadSends();
    runOp(3'd7, 3'd7, 32'h0004_5123, 32'h0, 1'b0, 0);
    runOp(3'd6, 3'd2, 32'h0000_1040, 32'h0000_CAFE, 1'b0, 0);
  endtask

  task automatic testUnderflow();
    runOp(3'd0, 3'd3, 32'h0000_0101, 32'h0000_5555, 1'b1, 0);
    runOp(3'd1, 3'd1, 32'h0000_0202, 32'h0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testModes();
    testZeroDst();
    testWrapAndStall();
    testLoadSends();
    testUnderflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule